// File: doc/BRIEF.md
# Oversampled Serial Receiver with Character Buffer

This block is the receive half of an asynchronous serial port. A free-running enable pulse at sixteen times the bit rate paces a sampler. The sampler detects a start bit, checks it at mid-bit, and then takes each data, parity and stop bit at the centre of its bit period. Each finished character goes into a receive buffer as a data byte together with a parity-error flag and a framing-error flag. The character length (5 to 8 bits), the parity and the number of stop bits come from line-setting inputs that the host holds steady.

A mode input selects how deep the buffer is. In single-character mode it holds one character. In buffered mode it holds up to sixteen in arrival order. A character that finds the buffer full is discarded and an overrun flag is raised; a status-read strobe clears that flag. A data-read strobe removes the oldest character, whose contents are shown on the read outputs. When the mode changes, the buffer is emptied. The receive interrupt works per character in single-character mode and by fill level against a selectable trigger in buffered mode.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset the buffer is empty (`level` 0, `data_ready` 0), `overrun` is 0 and `rx_irq` is 0.
- R2: A low on `rxd` is taken as a start bit only if it is still low at the 8th `tick16` pulse after the falling edge is seen. A shorter low stores nothing.
- R3: Data bits arrive LSB first. The length is given by `char_len` (0=5, 1=6, 2=7, 3=8 bits), and the unused upper bits of the stored byte read as 0.
- R4: When `parity_en`=1, one parity bit follows the data. `parity_even`=1 selects even parity and 0 selects odd. A mismatch sets the stored entry's parity-error flag. When `parity_en`=0 the flag is 0.
- R5: The stop bit is sampled at mid-bit, and a low sets the entry's framing-error flag. When `two_stop`=1 a second stop bit is also sampled, and a low there sets the flag too.
- R6: In buffered mode (`fifo_mode`=1) up to 16 entries are held and read out oldest first, and `level` reports the occupancy.
- R7: In single-character mode (`fifo_mode`=0) at most one entry is held.
- R8: A character that arrives when the buffer is full is dropped and leaves the stored entries unchanged. It sets `overrun`, which stays set until a `rd_stat_stb` pulse clears it.
- R9: In single-character mode `rx_irq` = `rx_int_en` AND an entry is held, so it clears when the entry is read out.
- R10: In buffered mode `rx_irq` is high while `rx_int_en`=1 and `level` is at least the trigger chosen by `trig_sel` (0=1, 1=4, 2=8, 3=14 entries).
- R11: A change of `fifo_mode` empties the buffer on the next clock edge.
- R12: A `rd_data_stb` pulse while the buffer is empty has no effect: `level` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| fifo_mode | input | 1 | 1 = 16-entry buffer, 0 = single character |
| char_len | input | 2 | Data bits: 0=5, 1=6, 2=7, 3=8 |
| parity_en | input | 1 | Parity bit present |
| parity_even | input | 1 | 1 = even parity, 0 = odd |
| two_stop | input | 1 | Check a second stop bit |
| trig_sel | input | 2 | Buffered-mode trigger: 1, 4, 8, 14 |
| rx_int_en | input | 1 | Receive interrupt enable |
| rd_data_stb | input | 1 | Remove the oldest entry |
| rd_stat_stb | input | 1 | Status read; clears overrun |
| rd_data | output | 8 | Data byte of the oldest entry |
| rd_perr | output | 1 | Parity error flag of the oldest entry |
| rd_ferr | output | 1 | Framing error flag of the oldest entry |
| data_ready | output | 1 | At least one entry held |
| level | output | 5 | Number of entries held |
| overrun | output | 1 | A character was dropped |
| rx_irq | output | 1 | Receive interrupt |

## Verification
Randomised frames of every length and parity setting are checked against a bench model of the buffer. A sampler that shifted MSB first, or that failed to trim short characters, would return the wrong bytes. A start glitch shorter than half a bit is applied, and a design that skipped the mid-bit check would store a junk character. Sending more characters than the buffer holds, in both modes, exposes a design that overwrites old data or never raises `overrun`. Corrupted parity, corrupted first and second stop bits, mode changes with data pending, and reads of an empty buffer target flags that stick, leftover entries and a count that goes below zero. Every trigger setting is checked against the fill level.

// File: rtl/uart_rx_pkg.sv
// Shared types and helpers for the serial receiver.
// Assumes data bytes are at most 8 bits wide.
package uart_rx_pkg;

    localparam int DATA_W = 8;

    // One buffered character with its per-character error flags.
    typedef struct packed {
        logic              perr;
        logic              ferr;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    // Receive sampler states.
    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP1,
        S_STOP2
    } rx_state_t;

    // Trigger threshold for a trigger-select code.
    function automatic int unsigned trig_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/uart_rx_sampler.sv
// Oversampling receive sampler: synchronises rxd, validates the start bit
// at mid-bit, collects data/parity/stop bits at bit centres and emits one
// entry per frame as a single-cycle push. Assumes line settings are held
// steady while a frame is in progress.
module uart_rx_sampler
    import uart_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rxd,
    input  logic [1:0] char_len,
    input  logic       parity_en,
    input  logic       parity_even,
    input  logic       two_stop,
    output logic       push_v,
    output rx_entry_t  push_ent
);

    localparam int CNT_W = $clog2(OSR);
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(OSR - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rx_s;
    rx_state_t              state;
    logic [CNT_W-1:0]       cnt;
    logic [2:0]             bit_idx;
    logic [DATA_W-1:0]      shreg;
    logic                   par_acc;
    logic                   perr_q;
    logic                   ferr_q;
    logic                   at_centre;

    // Synchronise the serial input (idle high at reset).
    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= rxd;
            end
        end else begin : g_syncn
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
            end
        end
    endgenerate

    assign rx_s      = sync_q[SYNC_STAGES-1];
    assign at_centre = (cnt == FULL_CNT);

    // Frame state machine, bit sampling and entry assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            cnt      <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            par_acc  <= 1'b0;
            perr_q   <= 1'b0;
            ferr_q   <= 1'b0;
            push_v   <= 1'b0;
            push_ent <= '0;
        end else begin
            push_v <= 1'b0;
            if (tick16) begin
                case (state)
                    S_IDLE: begin
                        cnt <= '0;
                        if (!rx_s) state <= S_START;
                    end
                    S_START: begin
                        if (cnt == MID_CNT) begin
                            cnt     <= '0;
                            bit_idx <= '0;
                            par_acc <= 1'b0;
                            perr_q  <= 1'b0;
                            ferr_q  <= 1'b0;
                            state   <= rx_s ? S_IDLE : S_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_DATA: begin
                        cnt <= cnt + 1'b1;
                        if (at_centre) begin
                            shreg   <= {rx_s, shreg[DATA_W-1:1]};
                            par_acc <= par_acc ^ rx_s;
                            if (bit_idx == {1'b1, char_len})
                                state <= parity_en ? S_PAR : S_STOP1;
                            else
                                bit_idx <= bit_idx + 1'b1;
                        end
                    end
                    S_PAR: begin
                        cnt <= cnt + 1'b1;
                        if (at_centre) begin
                            perr_q <= par_acc ^ rx_s ^ ~parity_even;
                            state  <= S_STOP1;
                        end
                    end
                    S_STOP1: begin
                        cnt <= cnt + 1'b1;
                        if (at_centre) begin
                            if (two_stop) begin
                                ferr_q <= ~rx_s;
                                state  <= S_STOP2;
                            end else begin
                                push_v        <= 1'b1;
                                push_ent.data <= shreg >> (2'd3 - char_len);
                                push_ent.perr <= perr_q;
                                push_ent.ferr <= ~rx_s;
                                state         <= S_IDLE;
                            end
                        end
                    end
                    S_STOP2: begin
                        cnt <= cnt + 1'b1;
                        if (at_centre) begin
                            push_v        <= 1'b1;
                            push_ent.data <= shreg >> (2'd3 - char_len);
                            push_ent.perr <= perr_q;
                            push_ent.ferr <= ferr_q | ~rx_s;
                            state         <= S_IDLE;
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/uart_rx_buf.sv
// Receive character buffer: a circular store of DEPTH entries whose usable
// capacity drops to one in single-character mode. Full pushes are dropped
// and latch an overrun flag; a flush empties it. Assumes DEPTH is a power
// of two.
module uart_rx_buf
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       cap_one,
    input  logic                       push,
    input  rx_entry_t                  wr_ent,
    input  logic                       pop,
    input  logic                       ovr_clr,
    output rx_entry_t                  head,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       ovr
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int LVL_W = $clog2(DEPTH + 1);

    rx_entry_t        mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             full;
    logic             empty;
    logic             do_push;
    logic             do_pop;

    assign empty   = (level == '0);
    assign full    = cap_one ? !empty : (level == LVL_W'(DEPTH));
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = mem[rd_ptr];

    // Entry storage write port.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wr_ent;
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // Overrun flag: set by a dropped push, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)                     ovr <= 1'b0;
        else if (push && full && !flush) ovr <= 1'b1;
        else if (ovr_clr)               ovr <= 1'b0;
    end

endmodule

// File: rtl/uart_rx_irq.sv
// Receive interrupt decision: per-character in single-character mode,
// fill level against a selected trigger in buffered mode.
module uart_rx_irq
    import uart_rx_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic             fifo_mode,
    input  logic             int_en,
    input  logic [1:0]       trig_sel,
    input  logic [LVL_W-1:0] level,
    output logic             irq
);

    logic [LVL_W-1:0] thresh;

    // Decode the trigger level and compare it with the occupancy.
    always_comb begin
        thresh = LVL_W'(trig_level(trig_sel));
        if (fifo_mode) irq = int_en && (level >= thresh);
        else           irq = int_en && (level != '0);
    end

endmodule

// File: rtl/uart_rx_fifo.sv
// Top of the serial receiver: sampler feeding a character buffer, with the
// receive interrupt derived from mode, enable and occupancy. A change of
// buffer mode flushes all held entries.
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int OSR   = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick16,
    input  logic             rxd,
    input  logic             fifo_mode,
    input  logic [1:0]       char_len,
    input  logic             parity_en,
    input  logic             parity_even,
    input  logic             two_stop,
    input  logic [1:0]       trig_sel,
    input  logic             rx_int_en,
    input  logic             rd_data_stb,
    input  logic             rd_stat_stb,
    output logic [7:0]       rd_data,
    output logic             rd_perr,
    output logic             rd_ferr,
    output logic             data_ready,
    output logic [LVL_W-1:0] level,
    output logic             overrun,
    output logic             rx_irq
);

    logic      push_v;
    rx_entry_t push_ent;
    rx_entry_t head;
    logic      mode_q;
    logic      flush;

    // Remember the previous mode so that a change triggers a flush.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= fifo_mode;
        else        mode_q <= fifo_mode;
    end

    assign flush = rst_n && (mode_q != fifo_mode);

    uart_rx_sampler #(.OSR(OSR), .SYNC_STAGES(2)) u_samp (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick16      (tick16),
        .rxd         (rxd),
        .char_len    (char_len),
        .parity_en   (parity_en),
        .parity_even (parity_even),
        .two_stop    (two_stop),
        .push_v      (push_v),
        .push_ent    (push_ent)
    );

    uart_rx_buf #(.DEPTH(DEPTH)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .cap_one (!fifo_mode),
        .push    (push_v),
        .wr_ent  (push_ent),
        .pop     (rd_data_stb),
        .ovr_clr (rd_stat_stb),
        .head    (head),
        .level   (level),
        .ovr     (overrun)
    );

    uart_rx_irq #(.LVL_W(LVL_W)) u_irq (
        .fifo_mode (fifo_mode),
        .int_en    (rx_int_en),
        .trig_sel  (trig_sel),
        .level     (level),
        .irq       (rx_irq)
    );

    assign rd_data    = head.data;
    assign rd_perr    = head.perr;
    assign rd_ferr    = head.ferr;
    assign data_ready = (level != '0);

endmodule

// File: rtl/uart_rx_fifo_chk.sv
// Property checker for the serial receiver, bound to the top module.
module uart_rx_fifo_chk #(
    parameter int DEPTH = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_mode,
    input logic             rx_int_en,
    input logic             rd_data_stb,
    input logic             rd_stat_stb,
    input logic             push_v,
    input logic [LVL_W-1:0] level,
    input logic             overrun,
    input logic             rx_irq
);

    // R1: the cycle after reset releases, the buffer is empty and clean.
    a_r1_reset_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (level == '0) && !overrun && !rx_irq);

    // R6: occupancy never exceeds the buffer depth.
    a_r6_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    // R7: single-character mode never holds more than one entry.
    a_r7_single_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_mode && $past(!fifo_mode)) |-> level <= LVL_W'(1));

    // R8: a push into a full buffer raises overrun and keeps the level.
    a_r8_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (push_v && !rd_data_stb && $stable(fifo_mode) &&
         (fifo_mode ? (level == LVL_W'(DEPTH)) : (level != '0)))
        |=> overrun && $stable(level));

    // R8: overrun holds until a status read.
    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !rd_stat_stb) |=> overrun);

    // R10: a buffer at the top trigger always requests an interrupt.
    a_r10_high_fill_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_mode && rx_int_en && level >= LVL_W'(14)) |-> rx_irq);

    // R9: no interrupt while disabled.
    a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_int_en |-> !rx_irq);

    // R11: a mode change leaves the buffer empty.
    a_r11_mode_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_mode != $past(fifo_mode) && $past(rst_n)) |=> level == '0);

    // R12: reading an empty buffer without a push keeps it empty.
    a_r12_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0 && rd_data_stb && !push_v) |=> level == '0);

endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_mode   (fifo_mode),
    .rx_int_en   (rx_int_en),
    .rd_data_stb (rd_data_stb),
    .rd_stat_stb (rd_stat_stb),
    .push_v      (push_v),
    .level       (level),
    .overrun     (overrun),
    .rx_irq      (rx_irq)
);

// File: tb/uart_rx_fifo_test.sv
// Self-checking bench for the serial receiver: random frames against a
// queue model plus directed corner cases.
module uart_rx_fifo_test;

    localparam int BIT_CLKS = 32;   // 16 ticks, one tick every 2 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic       fifo_mode = 1'b0;
    logic [1:0] char_len = 2'd3;
    logic       parity_en = 1'b0;
    logic       parity_even = 1'b0;
    logic       two_stop = 1'b0;
    logic [1:0] trig_sel = 2'd0;
    logic       rx_int_en = 1'b0;
    logic       rd_data_stb = 1'b0;
    logic       rd_stat_stb = 1'b0;
    logic [7:0] rd_data;
    logic       rd_perr;
    logic       rd_ferr;
    logic       data_ready;
    logic [4:0] level;
    logic       overrun;
    logic       rx_irq;

    int         n_checks = 0;
    int         n_fail = 0;
    bit         finished = 1'b0;
    logic [9:0] mq[$];
    bit         ovr_exp = 1'b0;

    uart_rx_fifo uut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .fifo_mode(fifo_mode), .char_len(char_len), .parity_en(parity_en),
        .parity_even(parity_even), .two_stop(two_stop), .trig_sel(trig_sel),
        .rx_int_en(rx_int_en), .rd_data_stb(rd_data_stb),
        .rd_stat_stb(rd_stat_stb), .rd_data(rd_data), .rd_perr(rd_perr),
        .rd_ferr(rd_ferr), .data_ready(data_ready), .level(level),
        .overrun(overrun), .rx_irq(rx_irq)
    );

    always #2 clk = ~clk;

    always @(negedge clk) tick16 <= ~tick16;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int trig_of(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic bit irq_model();
        if (!rx_int_en) return 1'b0;
        if (fifo_mode) return mq.size() >= trig_of(trig_sel);
        return mq.size() != 0;
    endfunction

    task automatic drive_bit(input logic v);
        rxd = v;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    // Send one frame under the current line settings and update the model.
    task automatic send(input logic [7:0] d, input bit bad_par,
                        input bit bad_s1, input bit bad_s2);
        int   nb;
        logic p;
        logic [7:0] md;
        nb = 5 + int'(char_len);
        p = 1'b0;
        @(negedge clk);
        drive_bit(1'b0);
        for (int i = 0; i < nb; i++) begin
            drive_bit(d[i]);
            p ^= d[i];
        end
        if (parity_en) drive_bit(p ^ ~parity_even ^ bad_par);
        drive_bit(~bad_s1);
        if (two_stop) drive_bit(~bad_s2);
        drive_bit(1'b1);
        md = d & (8'hFF >> (8 - nb));
        if (mq.size() >= (fifo_mode ? 16 : 1)) ovr_exp = 1'b1;
        else mq.push_back({bad_par & parity_en, bad_s1 | (two_stop & bad_s2), md});
    endtask

    // Compare the oldest entry with the model, then remove it.
    task automatic read_one(input string req);
        logic [9:0] e;
        @(negedge clk);
        e = mq.pop_front();
        check({rd_perr, rd_ferr, rd_data} == e, req,
              int'({rd_perr, rd_ferr, rd_data}), int'(e));
        rd_data_stb = 1'b1;
        @(negedge clk);
        rd_data_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic stat_read();
        @(negedge clk);
        rd_stat_stb = 1'b1;
        @(negedge clk);
        rd_stat_stb = 1'b0;
        ovr_exp = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int unused;
        unused = $urandom(32'd9173);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        check(level == 0, "R1 level", level, 0);
        check(!data_ready && !overrun, "R1 flags", {data_ready, overrun}, 0);
        check(!rx_irq, "R1 irq", rx_irq, 0);

        // R9: single-character interrupt set on arrival, cleared on read.
        rx_int_en = 1'b1;
        send(8'hA5, 0, 0, 0);
        check(rx_irq == 1'b1, "R9 irq on arrival", rx_irq, 1);
        read_one("R3 single byte");
        check(rx_irq == 1'b0, "R9 irq clear on read", rx_irq, 0);

        // R12: read of an empty buffer.
        rd_data_stb = 1'b1;
        @(negedge clk);
        rd_data_stb = 1'b0;
        @(negedge clk);
        check(level == 0, "R12 empty read", level, 0);

        // R7/R8: two characters in single mode -> second dropped.
        send(8'h3C, 0, 0, 0);
        send(8'hC3, 0, 0, 0);
        check(level == 1, "R7 single capacity", level, 1);
        check(overrun == ovr_exp && ovr_exp, "R8 overrun single", overrun, 1);
        read_one("R8 first kept");
        stat_read();
        check(overrun == 1'b0, "R8 clear by status read", overrun, 0);

        // R2: short start glitch is ignored.
        @(negedge clk);
        rxd = 1'b0;
        repeat (6) @(negedge clk);
        rxd = 1'b1;
        repeat (BIT_CLKS * 12) @(negedge clk);
        check(level == 0, "R2 glitch ignored", level, 0);

        // R11: mode change empties the buffer.
        send(8'h11, 0, 0, 0);
        check(level == 1, "R11 pre", level, 1);
        fifo_mode = 1'b1;
        repeat (3) @(negedge clk);
        mq.delete();
        check(level == 0, "R11 flush on mode change", level, 0);

        // R6/R8/R10/R3/R4/R5: random frames into the buffer, past capacity.
        for (int k = 0; k < 20; k++) begin
            char_len    = 2'($urandom_range(0, 3));
            parity_en   = 1'($urandom_range(0, 1));
            parity_even = 1'($urandom_range(0, 1));
            two_stop    = 1'($urandom_range(0, 1));
            trig_sel    = 2'($urandom_range(0, 3));
            send(8'($urandom), 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 4) == 0), 1'($urandom_range(0, 4) == 0));
            check(level == 5'(mq.size()), "R6 level", level, mq.size());
            check(rx_irq == irq_model(), "R10 trigger irq", rx_irq, irq_model());
            check(overrun == ovr_exp, "R8 overrun buffered", overrun, ovr_exp);
        end
        stat_read();
        check(overrun == 1'b0, "R8 clear buffered", overrun, 0);
        for (int t = 0; t < 4; t++) begin
            trig_sel = 2'(t);
            @(negedge clk);
            check(rx_irq == irq_model(), "R10 full trigger sweep", rx_irq, irq_model());
        end
        while (mq.size() != 0) begin
            trig_sel = 2'($urandom_range(0, 3));
            read_one("R6 order and R3/R4/R5 flags");
            check(rx_irq == irq_model(), "R10 irq while draining", rx_irq, irq_model());
        end

        // R4/R5: directed parity and stop-bit errors.
        char_len = 2'd3; parity_en = 1'b1; parity_even = 1'b1; two_stop = 1'b0;
        send(8'h81, 1, 0, 0);
        check(rd_perr == 1'b1 && rd_ferr == 1'b0, "R4 even parity error", {rd_perr, rd_ferr}, 2);
        read_one("R4 entry");
        parity_even = 1'b0;
        send(8'h7E, 0, 0, 0);
        check(rd_perr == 1'b0, "R4 odd parity good", rd_perr, 0);
        read_one("R4 odd entry");
        parity_en = 1'b0; two_stop = 1'b1;
        send(8'h5A, 0, 0, 1);
        check(rd_ferr == 1'b1, "R5 second stop low", rd_ferr, 1);
        read_one("R5 entry");
        two_stop = 1'b0;
        send(8'h0F, 0, 1, 0);
        check(rd_ferr == 1'b1, "R5 first stop low", rd_ferr, 1);
        read_one("R5 entry 2");
        char_len = 2'd0;
        send(8'hFF, 0, 0, 0);
        check(rd_data == 8'h1F, "R3 five-bit trim", rd_data, 8'h1F);
        read_one("R3 five-bit entry");

        // R9: interrupt disabled.
        rx_int_en = 1'b0;
        trig_sel = 2'd0;
        send(8'h12, 0, 0, 0);
        check(rx_irq == 1'b0, "R9 disabled", rx_irq, 0);
        read_one("R9 disabled entry");

        finish_run();
    end

endmodule